// File: doc/BRIEF.md
# Masked Even-Lane Duplicate Unit

This block is a permute stage for a 512-bit vector register datapath. The datapath is split into eight 64-bit lanes, grouped as four pairs. In each pair, the even-indexed source element is copied into both the even lane and the odd lane of the result. Values pass through unchanged, bit for bit. No arithmetic is done, so no status or floating-point exception output exists.

The caller chooses an operating width of 128, 256 or 512 bits and an encoding kind:
- **Legacy kind:** always works on the low 128 bits and keeps every register bit above them.
- **Plain kind:** works at the chosen width and clears everything above it.
- **Masked kind:** also clears above the width. A per-lane writemask then decides which active lanes receive the duplicated value. The other active lanes either keep the old destination value (merge) or become zero (zero).

In the non-legacy kinds, a reserved 4-bit operand field that is not all ones marks the operation as an illegal encoding. In that case the destination write is suppressed.

Inputs are captured on a clock edge where `in_valid` is high. The result is registered and presented one clock later with a single-cycle `out_valid`.

Top module: `dup_unit`

## Requirements
- R1: For each lane pair p (lanes 2p and 2p+1, where lane l occupies bits 64l+63:64l), both result lanes equal source lane 2p bit for bit. This applies to every active lane that is not masked off.
- R2: `width_sel` encodes the operating width: 0 = 128 bits (2 lanes), 1 = 256 bits (4 lanes), 2 and 3 = 512 bits (8 lanes).
- R3: `enc_kind` 2 is the masked kind. `enc_kind` 1 and 3 are plain kinds and `enc_kind` 0 is legacy. In the plain and legacy kinds the mask and `zero_mask` have no effect, and every active lane receives the duplicated value.
- R4: In the masked kind, `mask` bit l controls lane l. Bit 1 gives the duplicated value. Bit 0 gives the old destination lane when `zero_mask` is 0, and zero when `zero_mask` is 1.
- R5: In the legacy kind the width is fixed at 128 bits and result bits 511:128 equal the old destination. `width_sel` and `rsvd_field` have no effect in this kind.
- R6: In the plain and masked kinds, result bits from the operating width up to bit 511 are zero.
- R7: In a non-legacy kind with `rsvd_field` not equal to 4'b1111, the result has `out_undef`=1 and `out_wr_en`=0, and `out_vec` equals the old destination. In every other case `out_undef`=0 and `out_wr_en`=1.
- R8: Mask bits for lanes at or above the operating width have no effect on the result.
- R9: A high `in_valid` at a clock edge produces `out_valid`=1 for exactly the following cycle, carrying that operation's result. Back-to-back operations give back-to-back results.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_vec`, `out_wr_en` and `out_undef` to zero.
- R11: Special floating-point bit patterns (NaN payloads, negative zero, denormals) are copied unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request; inputs are sampled when high |
| src_vec | input | 512 | Source vector |
| old_dst | input | 512 | Current destination register value |
| width_sel | input | 2 | Operating width code |
| enc_kind | input | 2 | Encoding kind: 0 legacy, 1/3 plain, 2 masked |
| mask | input | 8 | Per-lane writemask, bit l for lane l |
| zero_mask | input | 1 | 1 = zero masked-off lanes, 0 = merge old value |
| rsvd_field | input | 4 | Reserved operand field, must be all ones |
| out_valid | output | 1 | Result valid, one cycle per request |
| out_vec | output | 512 | Result vector |
| out_wr_en | output | 1 | Destination write enable |
| out_undef | output | 1 | Illegal-encoding flag |

## Verification
The bench builds the unit with its default parameters: eight lanes of 64 bits. This makes all three operating widths reachable, and so also both the full-width case and the two cases where upper pairs are cleared or preserved. With eight mask bits the bench can set mask bits for lanes above 128 and 256 bits and show that they change nothing. It also mixes merge and zero patterns across all four pairs. The reserved-field check is exercised in the plain, masked and legacy kinds, so both the suppression path and the legacy exemption are reached.

// File: rtl/dup_pkg.sv
package dup_pkg;

   typedef enum logic [1:0] {
      ENC_LEGACY    = 2'd0,
      ENC_PLAIN     = 2'd1,
      ENC_MASKED    = 2'd2,
      ENC_PLAIN_ALT = 2'd3
   } enc_kind_e;

   typedef enum logic [1:0] {
      PICK_DUP  = 2'd0,
      PICK_OLD  = 2'd1,
      PICK_ZERO = 2'd2
   } lane_pick_e;

   // Number of lanes the operation touches, capped at the datapath size.
   function automatic int req_lanes(input logic [1:0] enc,
                                    input logic [1:0] wsel,
                                    input int         cap);
      int n;
      if (enc == ENC_LEGACY) begin
         n = 2;
      end else begin
         case (wsel)
            2'd0:    n = 2;
            2'd1:    n = 4;
            default: n = 8;
         endcase
      end
      if (n > cap) n = cap;
      return n;
   endfunction

endpackage

// File: rtl/dup_pair_spread.sv
module dup_pair_spread #(
   parameter int LANE_W    = 64,
   parameter int NUM_LANES = 8,
   localparam int VEC_W    = LANE_W * NUM_LANES,
   localparam int NUM_PAIRS = NUM_LANES / 2
) (
   input  logic [VEC_W-1:0] src_vec,
   output logic [VEC_W-1:0] dup_vec
);

   generate
      for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
         localparam int EVEN_LO = 2 * p * LANE_W;
         localparam int ODD_LO  = (2 * p + 1) * LANE_W;
         assign dup_vec[EVEN_LO +: LANE_W] = src_vec[EVEN_LO +: LANE_W];
         assign dup_vec[ODD_LO  +: LANE_W] = src_vec[EVEN_LO +: LANE_W];
      end
   endgenerate

endmodule

// File: rtl/dup_lane_ctrl.sv
module dup_lane_ctrl
   import dup_pkg::*;
#(
   parameter int NUM_LANES = 8,
   parameter int RSVD_W    = 4
) (
   input  logic [1:0]              enc_kind,
   input  logic [1:0]              width_sel,
   input  logic [NUM_LANES-1:0]    mask,
   input  logic                    zero_mask,
   input  logic [RSVD_W-1:0]       rsvd_field,
   output lane_pick_e [NUM_LANES-1:0] picks,
   output logic                    undef
);

   logic is_legacy;
   logic is_masked;
   int   active_n;

   always_comb begin
      is_legacy = (enc_kind == ENC_LEGACY);
      is_masked = (enc_kind == ENC_MASKED);
      undef     = !is_legacy && (rsvd_field != {RSVD_W{1'b1}});
      active_n  = req_lanes(enc_kind, width_sel, NUM_LANES);
   end

   generate
      for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
         always_comb begin
            if (undef) begin
               picks[l] = PICK_OLD;
            end else if (l >= active_n) begin
               picks[l] = is_legacy ? PICK_OLD : PICK_ZERO;
            end else if (is_masked && !mask[l]) begin
               picks[l] = zero_mask ? PICK_ZERO : PICK_OLD;
            end else begin
               picks[l] = PICK_DUP;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dup_lane_mux.sv
module dup_lane_mux
   import dup_pkg::*;
#(
   parameter int LANE_W    = 64,
   parameter int NUM_LANES = 8,
   localparam int VEC_W    = LANE_W * NUM_LANES
) (
   input  logic [VEC_W-1:0]           dup_vec,
   input  logic [VEC_W-1:0]           old_vec,
   input  lane_pick_e [NUM_LANES-1:0] picks,
   output logic [VEC_W-1:0]           res_vec
);

   generate
      for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
         always_comb begin
            case (picks[l])
               PICK_DUP: res_vec[l*LANE_W +: LANE_W] = dup_vec[l*LANE_W +: LANE_W];
               PICK_OLD: res_vec[l*LANE_W +: LANE_W] = old_vec[l*LANE_W +: LANE_W];
               default:  res_vec[l*LANE_W +: LANE_W] = '0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/dup_unit.sv
module dup_unit
   import dup_pkg::*;
#(
   parameter int LANE_W    = 64,
   parameter int NUM_LANES = 8,
   parameter int RSVD_W    = 4,
   localparam int VEC_W    = LANE_W * NUM_LANES,
   localparam int PAIR_W   = 2 * LANE_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [VEC_W-1:0]     src_vec,
   input  logic [VEC_W-1:0]     old_dst,
   input  logic [1:0]           width_sel,
   input  logic [1:0]           enc_kind,
   input  logic [NUM_LANES-1:0] mask,
   input  logic                 zero_mask,
   input  logic [RSVD_W-1:0]    rsvd_field,
   output logic                 out_valid,
   output logic [VEC_W-1:0]     out_vec,
   output logic                 out_wr_en,
   output logic                 out_undef
);

   generate
      if (NUM_LANES != 2 && NUM_LANES != 4 && NUM_LANES != 8) begin : g_bad_lanes
         $error("dup_unit: NUM_LANES must be 2, 4 or 8");
      end
      if (LANE_W < 1) begin : g_bad_lane_w
         $error("dup_unit: LANE_W must be positive");
      end
      if (RSVD_W < 1) begin : g_bad_rsvd_w
         $error("dup_unit: RSVD_W must be positive");
      end
   endgenerate

   logic [VEC_W-1:0]           dup_vec;
   logic [VEC_W-1:0]           res_vec;
   lane_pick_e [NUM_LANES-1:0] picks;
   logic                       undef;

   dup_pair_spread #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_spread (
      .src_vec (src_vec),
      .dup_vec (dup_vec)
   );

   dup_lane_ctrl #(.NUM_LANES(NUM_LANES), .RSVD_W(RSVD_W)) u_ctrl (
      .enc_kind   (enc_kind),
      .width_sel  (width_sel),
      .mask       (mask),
      .zero_mask  (zero_mask),
      .rsvd_field (rsvd_field),
      .picks      (picks),
      .undef      (undef)
   );

   dup_lane_mux #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_mux (
      .dup_vec (dup_vec),
      .old_vec (old_dst),
      .picks   (picks),
      .res_vec (res_vec)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
         out_wr_en <= 1'b0;
         out_undef <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_vec   <= res_vec;
            out_wr_en <= !undef;
            out_undef <= undef;
         end
      end
   end

   // ---------------- assertions ----------------
   logic rsvd_ok;
   assign rsvd_ok = (rsvd_field == {RSVD_W{1'b1}});

   // R7: an illegal encoding never writes and returns the old destination
   p_undef_keeps_old_r7: assert property (@(posedge clk) disable iff (rst)
      in_valid && enc_kind != ENC_LEGACY && !rsvd_ok
      |=> out_undef && !out_wr_en && out_vec == $past(old_dst));

   // R7: write enable and undef flag are exclusive on every result
   p_wr_en_vs_undef_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_wr_en != out_undef));

   // R4: a zeroing mask clears lane 0 when its bit is low
   p_zero_lane0_r4: assert property (@(posedge clk) disable iff (rst)
      in_valid && enc_kind == ENC_MASKED && rsvd_ok && zero_mask && !mask[0]
      |=> out_vec[LANE_W-1:0] == '0);

   // R1: pair 0 is always active when unmasked
   p_pair0_dup_r1: assert property (@(posedge clk) disable iff (rst)
      in_valid && enc_kind != ENC_MASKED && (rsvd_ok || enc_kind == ENC_LEGACY)
      |=> out_vec[LANE_W-1:0] == $past(src_vec[LANE_W-1:0]) &&
          out_vec[PAIR_W-1:LANE_W] == $past(src_vec[LANE_W-1:0]));

   generate
      if (NUM_LANES > 2) begin : g_upper_chk
         // R5: legacy keeps everything above the first pair
         p_legacy_upper_r5: assert property (@(posedge clk) disable iff (rst)
            in_valid && enc_kind == ENC_LEGACY
            |=> out_vec[VEC_W-1:PAIR_W] == $past(old_dst[VEC_W-1:PAIR_W]));

         // R6: a 128-bit non-legacy operation clears everything above it
         p_clear_upper_r6: assert property (@(posedge clk) disable iff (rst)
            in_valid && enc_kind != ENC_LEGACY && rsvd_ok && width_sel == 2'd0
            |=> out_vec[VEC_W-1:PAIR_W] == '0);
      end

      for (genvar p = 0; p < NUM_LANES / 2; p++) begin : g_full_chk
         // R1: at full width in a plain kind every pair carries its even lane
         p_full_pair_r1: assert property (@(posedge clk) disable iff (rst)
            in_valid && (enc_kind == ENC_PLAIN || enc_kind == ENC_PLAIN_ALT) &&
            rsvd_ok && width_sel[1]
            |=> out_vec[2*p*LANE_W +: LANE_W] == $past(src_vec[2*p*LANE_W +: LANE_W]) &&
                out_vec[(2*p+1)*LANE_W +: LANE_W] == $past(src_vec[2*p*LANE_W +: LANE_W]));
      end
   endgenerate

endmodule

// File: tb/sim_dup_unit.sv
module sim_dup_unit;
   localparam int CLK_PERIOD = 10;
   localparam int LW = 64;
   localparam int NL = 8;
   localparam int VW = LW * NL;
   localparam int ROWS = 12;

   // row layout: enc[24:23] wsel[22:21] mask[20:13] zm[12] rsvd[11:8] seed[7:0]
   localparam logic [24:0] TABLE [ROWS] = '{
      {2'd1, 2'd2, 8'h00, 1'b0, 4'hF, 8'h11},  // plain 512
      {2'd1, 2'd1, 8'h00, 1'b0, 4'hF, 8'h22},  // plain 256
      {2'd1, 2'd0, 8'hFF, 1'b1, 4'hF, 8'h33},  // plain 128, mask ignored
      {2'd2, 2'd2, 8'hA5, 1'b0, 4'hF, 8'h44},  // masked merge
      {2'd2, 2'd2, 8'h5A, 1'b1, 4'hF, 8'h55},  // masked zero
      {2'd2, 2'd1, 8'hF6, 1'b1, 4'hF, 8'h66},  // masked zero 256, high bits set
      {2'd2, 2'd0, 8'hFE, 1'b0, 4'hF, 8'h77},  // masked merge 128
      {2'd0, 2'd2, 8'h00, 1'b1, 4'h0, 8'h88},  // legacy, bad rsvd ignored
      {2'd0, 2'd1, 8'h3C, 1'b0, 4'hF, 8'h99},  // legacy, wsel ignored
      {2'd1, 2'd2, 8'hFF, 1'b0, 4'hE, 8'hAA},  // plain undef
      {2'd2, 2'd0, 8'h0F, 1'b1, 4'h7, 8'hBB},  // masked undef
      {2'd3, 2'd3, 8'h00, 1'b1, 4'hF, 8'hCC}   // alternate plain, wsel 3
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [VW-1:0] src_vec = '0;
   logic [VW-1:0] old_dst = '0;
   logic [1:0]    width_sel = '0;
   logic [1:0]    enc_kind = '0;
   logic [NL-1:0] mask = '0;
   logic          zero_mask = 1'b0;
   logic [3:0]    rsvd_field = 4'hF;
   logic          out_valid;
   logic [VW-1:0] out_vec;
   logic          out_wr_en;
   logic          out_undef;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dup_unit u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
      .old_dst(old_dst), .width_sel(width_sel), .enc_kind(enc_kind),
      .mask(mask), .zero_mask(zero_mask), .rsvd_field(rsvd_field),
      .out_valid(out_valid), .out_vec(out_vec), .out_wr_en(out_wr_en),
      .out_undef(out_undef)
   );

   function automatic logic [VW-1:0] mkvec(input logic [7:0] seed);
      logic [VW-1:0] v;
      for (int l = 0; l < NL; l++)
         v[l*LW +: LW] = {seed, 8'(l), 16'hC0DE, 32'h1357_9BDF ^ {4{seed}}};
      return v;
   endfunction

   function automatic void model(input logic [1:0] enc, input logic [1:0] wsel,
                                 input logic [7:0] mk, input logic zm,
                                 input logic [3:0] rs, input logic [VW-1:0] s,
                                 input logic [VW-1:0] o, output logic [VW-1:0] v,
                                 output logic wr, output logic ud);
      int act;
      ud = (enc != 2'd0) && (rs != 4'hF);
      wr = !ud;
      act = (enc == 2'd0) ? 2 : (wsel == 2'd0 ? 2 : (wsel == 2'd1 ? 4 : 8));
      for (int l = 0; l < NL; l++) begin
         if (ud)
            v[l*LW +: LW] = o[l*LW +: LW];
         else if (l >= act)
            v[l*LW +: LW] = (enc == 2'd0) ? o[l*LW +: LW] : '0;
         else if (enc == 2'd2 && !mk[l])
            v[l*LW +: LW] = zm ? '0 : o[l*LW +: LW];
         else
            v[l*LW +: LW] = s[(l & ~1)*LW +: LW];
      end
   endfunction

   function automatic string row_tag(input logic [1:0] enc, input logic [3:0] rs);
      if (enc != 2'd0 && rs != 4'hF) return "R7";
      if (enc == 2'd0) return "R5";
      if (enc == 2'd2) return "R4";
      return "R1";
   endfunction

   task automatic chk_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: out_vec actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: %s actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] enc, input logic [1:0] wsel, input logic [7:0] mk,
                        input logic zm, input logic [3:0] rs,
                        input logic [VW-1:0] s, input logic [VW-1:0] o);
      enc_kind = enc; width_sel = wsel; mask = mk; zero_mask = zm;
      rsvd_field = rs; src_vec = s; old_dst = o; in_valid = 1'b1;
   endtask

   // one operation: drive at negedge, result registered at next posedge, sampled at next negedge
   task automatic run_op(input string req, input logic [1:0] enc, input logic [1:0] wsel,
                         input logic [7:0] mk, input logic zm, input logic [3:0] rs,
                         input logic [VW-1:0] s, input logic [VW-1:0] o);
      logic [VW-1:0] ev;
      logic ew, eu;
      @(negedge clk);
      drive(enc, wsel, mk, zm, rs, s, o);
      @(negedge clk);
      in_valid = 1'b0;
      model(enc, wsel, mk, zm, rs, s, o, ev, ew, eu);
      chk_bit("R9", "out_valid", out_valid, 1'b1);
      chk_vec(req, out_vec, ev);
      chk_bit(req, "out_wr_en", out_wr_en, ew);
      chk_bit(req, "out_undef", out_undef, eu);
      @(negedge clk);
      chk_bit("R9", "out_valid pulse end", out_valid, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [VW-1:0] ev, ev2, s, o;
      logic ew, eu;

      repeat (3) @(negedge clk);
      // R10: reset state
      chk_bit("R10", "out_valid", out_valid, 1'b0);
      chk_vec("R10", out_vec, '0);
      chk_bit("R10", "out_wr_en", out_wr_en, 1'b0);
      chk_bit("R10", "out_undef", out_undef, 1'b0);
      rst = 1'b0;

      // table walk: R1 R2 R3 R4 R5 R6 R7 R8
      for (int r = 0; r < ROWS; r++) begin
         logic [24:0] e;
         e = TABLE[r];
         run_op(row_tag(e[24:23], e[11:8]), e[24:23], e[22:21], e[20:13], e[12],
                e[11:8], mkvec(e[7:0]), mkvec(~e[7:0]));
      end

      // R2: width 256 zeroes pairs 2 and 3, keeps pairs 0 and 1
      s = mkvec(8'h12); o = mkvec(8'hED);
      run_op("R2", 2'd1, 2'd1, 8'h00, 1'b0, 4'hF, s, o);

      // R6: width 128 masked merge, old upper data must not survive
      run_op("R6", 2'd2, 2'd0, 8'h03, 1'b0, 4'hF, s, o);

      // R8: mask bits of lanes 2..7 at width 128 do not change the result
      run_op("R8", 2'd2, 2'd0, 8'hFD, 1'b1, 4'hF, s, o);
      model(2'd2, 2'd0, 8'h01, 1'b1, 4'hF, s, o, ev2, ew, eu);
      chk_vec("R8", out_vec, ev2);

      // R3: plain kind with an all-zero zeroing mask still writes all lanes
      run_op("R3", 2'd1, 2'd2, 8'h00, 1'b1, 4'hF, s, o);

      // R11: special bit patterns copied unchanged
      s = '0;
      s[0*LW +: LW] = 64'h7FF8_0000_0000_0001;
      s[2*LW +: LW] = 64'h8000_0000_0000_0000;
      s[4*LW +: LW] = 64'h0000_0000_0000_0001;
      s[6*LW +: LW] = 64'hFFF0_0000_0000_0000;
      s[1*LW +: LW] = 64'h1111_1111_1111_1111;
      run_op("R11", 2'd1, 2'd2, 8'h00, 1'b0, 4'hF, s, o);

      // R9: back-to-back requests
      @(negedge clk);
      drive(2'd1, 2'd2, 8'h00, 1'b0, 4'hF, mkvec(8'h01), mkvec(8'hF0));
      @(negedge clk);
      model(2'd1, 2'd2, 8'h00, 1'b0, 4'hF, mkvec(8'h01), mkvec(8'hF0), ev, ew, eu);
      drive(2'd2, 2'd1, 8'h9C, 1'b0, 4'hF, mkvec(8'h02), mkvec(8'hE0));
      chk_bit("R9", "out_valid first", out_valid, 1'b1);
      chk_vec("R9", out_vec, ev);
      @(negedge clk);
      in_valid = 1'b0;
      model(2'd2, 2'd1, 8'h9C, 1'b0, 4'hF, mkvec(8'h02), mkvec(8'hE0), ev, ew, eu);
      chk_bit("R9", "out_valid second", out_valid, 1'b1);
      chk_vec("R9", out_vec, ev);
      @(negedge clk);
      chk_bit("R9", "out_valid after burst", out_valid, 1'b0);

      // R10: reset after activity clears outputs
      rst = 1'b1;
      @(negedge clk);
      chk_bit("R10", "out_valid after reset", out_valid, 1'b0);
      chk_vec("R10", out_vec, '0);
      chk_bit("R10", "out_wr_en after reset", out_wr_en, 1'b0);
      rst = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule